// File: doc/BRIEF.md
# Posit Word Decoder (32-bit, two exponent bits)

This block takes one 32-bit posit word with two exponent bits and unpacks it into a form that a multiplier or a wide accumulator can use directly. The outputs are a separate sign, an 8-bit biased exponent and a 28-bit significand whose top bit is the hidden one. A negative word is first turned into its magnitude by two's complement. A run counter then measures the regime, and a left shift moves the exponent and fraction bits to fixed places.

The exponent is built by copying bits, not by adding. Its top bit is the first regime bit of the magnitude. The next five bits are the run count, inverted when the regime is negative and taken as is when it is positive. The two exponent bits fill the bottom. The result always equals four times the regime value, plus the exponent bits, plus a bias of 128.

The all-zero word and the not-a-real word (only bit 31 set) skip decoding and raise their own flags. The decoder is a two-stage pipeline. A word sampled with its strobe high appears on the outputs two clock edges later, and the output strobe rises in that same cycle.

Top module: `posit_dec`

## Requirements
- R1: An input of 32'h00000000 produces out_zero=1 and out_nar=0, with out_sign, out_exp and out_frac all 0.
- R2: An input of 32'h80000000 produces out_nar=1 and out_zero=0, with out_sign, out_exp and out_frac all 0.
- R3: For any other word, out_sign equals bit 31 of the input. A word with bit 31 set is decoded from its two's complement, so a word and its negation give the same out_exp and out_frac.
- R4: For a normal word, out_exp[7] equals bit 30 of the magnitude (the first regime bit), and out_exp[1:0] are the two bits that follow the regime terminator, MSB first. Missing bits past the end of the word read as 0.
- R5: When the regime starts with 1, out_exp[6:2] equals the regime run length minus one. For example, 32'h40000000 (one) gives out_exp=128, and the largest word 32'h7FFFFFFF gives out_exp=248.
- R6: When the regime starts with 0, out_exp[6:2] equals the bitwise inverse of the run length minus one. For example, the smallest word 32'h00000001 gives out_exp=8.
- R7: For a normal word, out_frac[27] is 1 and out_frac[26:0] holds the fraction bits after the exponent bits, MSB first, padded with zeros on the right.
- R8: out_valid equals in_valid delayed by exactly two clock cycles. Output fields for a word appear in the cycle in which out_valid is high for it, and consecutive words can be accepted on every cycle.
- R9: While rst is high and in the first cycle after it, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe for in_word |
| in_word | input | 32 | Posit word to decode |
| out_valid | output | 1 | Strobe for the decoded fields, two cycles after in_valid |
| out_sign | output | 1 | Sign of the value |
| out_exp | output | 8 | Biased exponent, four times the regime plus the exponent bits plus 128 |
| out_frac | output | 28 | Significand with hidden one at bit 27 |
| out_zero | output | 1 | Input was the zero word |
| out_nar | output | 1 | Input was the not-a-real word |

## Verification
The test vectors cover several cases, each aimed at a different part of the logic. Unit values such as plus and minus one check the single-bit regime. The largest and smallest words check both 5-bit count paths at their limits. Words with very long regimes check that exponent bits cut off by the end of the word come out as zeros. Mixed words with dense fractions check the shifter and the order of fraction bits. Pairs of a word and its negation separate the sign path from the magnitude path. The two special words check that they bypass decoding. A back-to-back stream with gaps in the strobe checks the two-cycle alignment of each result with its strobe.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

    parameter int PW    = 32;
    parameter int ES    = 2;
    parameter int EXP_W = 8;

    localparam int MAG_W  = PW - 1;           // bits below the sign
    localparam int CNT_W  = $clog2(MAG_W);    // run count width
    localparam int SH_W   = CNT_W + 1;        // shift amount width
    localparam int FBITS  = PW - ES - 3;      // stored fraction bits
    localparam int FRAC_W = FBITS + 1;        // with hidden one

    typedef struct packed {
        logic             sign;
        logic             zero;
        logic             nar;
        logic [MAG_W-1:0] mag;
    } front_t;

    typedef struct packed {
        logic              sign;
        logic              zero;
        logic              nar;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } dec_t;

    // Copy the regime into the exponent field: the count is taken as is
    // for a positive regime and inverted for a negative one.
    function automatic logic [EXP_W-1:0] pack_exp(input logic r0,
                                                  input logic [CNT_W-1:0] cnt,
                                                  input logic [ES-1:0] ebits);
        logic [CNT_W-1:0] field;
        field = r0 ? cnt : ~cnt;
        return {r0, field, ebits};
    endfunction

endpackage

// File: rtl/posit_dec_front.sv
module posit_dec_front
    import posit_dec_pkg::*;
(
    input  logic [PW-1:0] word,
    output front_t        front
);
    logic [PW-1:0] abs_w;
    logic          is_zero;
    logic          is_nar;

    always_comb begin
        is_zero = (word == '0);
        is_nar  = (word == {1'b1, {(PW-1){1'b0}}});
        abs_w   = word[PW-1] ? (~word + 1'b1) : word;
        front.sign = word[PW-1] & ~is_nar;
        front.zero = is_zero;
        front.nar  = is_nar;
        front.mag  = abs_w[MAG_W-1:0];
    end
endmodule

// File: rtl/posit_dec_lzc.sv
module posit_dec_lzc
    import posit_dec_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    output logic [CNT_W-1:0] cnt
);
    // Bits after the first regime bit, flipped so the run becomes zeros.
    logic [MAG_W-2:0] tail;

    always_comb begin
        tail = mag[MAG_W-1] ? ~mag[MAG_W-2:0] : mag[MAG_W-2:0];
        cnt  = CNT_W'(MAG_W - 1);
        for (int i = 0; i < MAG_W - 1; i++) begin
            if (tail[i]) cnt = CNT_W'(MAG_W - 2 - i);
        end
    end
endmodule

// File: rtl/posit_dec_align.sv
module posit_dec_align
    import posit_dec_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    input  logic [CNT_W-1:0] cnt,
    output logic [ES-1:0]    ebits,
    output logic [FBITS-1:0] fbits
);
    logic [SH_W-1:0]  shamt;
    logic [MAG_W-1:0] moved;

    always_comb begin
        // drop the run (cnt+1 bits) and its terminator
        shamt = {1'b0, cnt} + SH_W'(2);
        moved = mag << shamt;
        ebits = moved[MAG_W-1 -: ES];
        fbits = moved[MAG_W-1-ES -: FBITS];
    end
endmodule

// File: rtl/posit_dec.sv
module posit_dec
    import posit_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PW-1:0]     in_word,
    output logic              out_valid,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [FRAC_W-1:0] out_frac,
    output logic              out_zero,
    output logic              out_nar
);
    front_t           front_c, front_q;
    logic             s1_vld;
    logic [CNT_W-1:0] run_cnt;
    logic [ES-1:0]    ebits;
    logic [FBITS-1:0] fbits;
    dec_t             dec_c, dec_q;
    logic             s2_vld;

    posit_dec_front u_front (.word(in_word), .front(front_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            front_q <= '0;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) front_q <= front_c;
        end
    end

    posit_dec_lzc   u_lzc   (.mag(front_q.mag), .cnt(run_cnt));
    posit_dec_align u_align (.mag(front_q.mag), .cnt(run_cnt),
                             .ebits(ebits), .fbits(fbits));

    always_comb begin
        dec_c      = '0;
        dec_c.zero = front_q.zero;
        dec_c.nar  = front_q.nar;
        if (!front_q.zero && !front_q.nar) begin
            dec_c.sign = front_q.sign;
            dec_c.exp  = pack_exp(front_q.mag[MAG_W-1], run_cnt, ebits);
            dec_c.frac = {1'b1, fbits};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
            dec_q  <= '0;
        end else begin
            s2_vld <= s1_vld;
            if (s1_vld) dec_q <= dec_c;
        end
    end

    assign out_valid = s2_vld;
    assign out_sign  = dec_q.sign;
    assign out_exp   = dec_q.exp;
    assign out_frac  = dec_q.frac;
    assign out_zero  = dec_q.zero;
    assign out_nar   = dec_q.nar;
endmodule

// File: rtl/posit_dec_chk.sv
module posit_dec_chk
    import posit_dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [PW-1:0]     in_word,
    input logic              out_valid,
    input logic              out_sign,
    input logic [EXP_W-1:0]  out_exp,
    input logic [FRAC_W-1:0] out_frac,
    input logic              out_zero,
    input logic              out_nar
);
    logic v_d1, v_d2, z_d1, z_d2, n_d1, n_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_d1 <= 1'b0; v_d2 <= 1'b0;
            z_d1 <= 1'b0; z_d2 <= 1'b0;
            n_d1 <= 1'b0; n_d2 <= 1'b0;
        end else begin
            v_d1 <= in_valid; v_d2 <= v_d1;
            z_d1 <= in_valid && (in_word == '0); z_d2 <= z_d1;
            n_d1 <= in_valid && (in_word == {1'b1, {(PW-1){1'b0}}}); n_d2 <= n_d1;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_d2);                                            // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !out_valid);                                           // R9
    AST_ZERO_SEEN: assert property (@(posedge clk) disable iff (rst)
        z_d2 |-> (out_zero && !out_nar && out_exp == '0 && out_frac == '0 && !out_sign)); // R1
    AST_NAR_SEEN: assert property (@(posedge clk) disable iff (rst)
        n_d2 |-> (out_nar && !out_zero && out_exp == '0 && out_frac == '0 && !out_sign)); // R2
    AST_HIDDEN_ONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero && !out_nar) |-> out_frac[FRAC_W-1]);  // R7
    AST_EXP_SPAN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero && !out_nar) |-> (out_exp >= 8'd8 && out_exp <= 8'd248)); // R5
endmodule

bind posit_dec posit_dec_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_frac(out_frac), .out_zero(out_zero), .out_nar(out_nar)
);

// File: tb/posit_dec_tb_top.sv
`timescale 1ns/1ps
module posit_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid, out_sign, out_zero, out_nar;
    logic [7:0]  out_exp;
    logic [27:0] out_frac;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    posit_dec dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
        .out_frac(out_frac), .out_zero(out_zero), .out_nar(out_nar)
    );

    // Reference: computed from the value formula, not by bit copying.
    task automatic ref_decode(input logic [31:0] w, output logic s, output logic [7:0] ex,
                              output logic [27:0] fr, output logic z, output logic n);
        logic [31:0] m;
        int run, k, pos, ev, idx;
        logic r0;
        s = 0; ex = 0; fr = 0; z = 0; n = 0;
        if (w == 32'h0) begin z = 1; return; end
        if (w == 32'h80000000) begin n = 1; return; end
        s = w[31];
        m = w[31] ? -w : w;
        r0 = m[30];
        run = 0;
        for (int i = 30; i >= 0; i--) begin
            if (m[i] == r0) run++; else break;
        end
        k = r0 ? run - 1 : -run;
        pos = 30 - run - 1;
        ev = 0;
        for (int j = 0; j < 2; j++) begin
            idx = pos - j;
            ev = ev * 2 + ((idx >= 0) ? int'(m[idx]) : 0);
        end
        ex = 8'(4 * k + ev + 128);
        fr = 28'h8000000;
        for (int j = 0; j < 27; j++) begin
            idx = pos - 2 - j;
            if (idx >= 0) fr[26 - j] = m[idx];
        end
    endtask

    task automatic check_out(input string tag, input logic [31:0] w);
        logic s, z, n;
        logic [7:0] ex;
        logic [27:0] fr;
        ref_decode(w, s, ex, fr, z, n);
        n_checks++;
        if (out_valid !== 1'b1 || out_sign !== s || out_exp !== ex || out_frac !== fr ||
            out_zero !== z || out_nar !== n) begin
            n_fail++;
            $display("FAIL %s word=%h actual v=%b s=%b e=%0d f=%h z=%b n=%b expected v=1 s=%b e=%0d f=%h z=%b n=%b",
                     tag, w, out_valid, out_sign, out_exp, out_frac, out_zero, out_nar,
                     s, ex, fr, z, n);
        end
    endtask

    task automatic check_lit(input string tag, input logic [31:0] w, input logic [7:0] ex_lit);
        n_checks++;
        if (out_exp !== ex_lit) begin
            n_fail++;
            $display("FAIL %s word=%h actual exp=%0d expected exp=%0d", tag, w, out_exp, ex_lit);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_word = w;
        @(negedge clk);
        in_valid = 1'b0; in_word = '0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b1; in_word = 32'h40000000;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++; $display("FAIL R9 during reset actual out_valid=%b expected 0", out_valid);
        end
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++; $display("FAIL R9 after reset actual out_valid=%b expected 0", out_valid);
        end
    endtask

    task automatic t_specials;
        apply(32'h00000000); check_out("R1 zero word", 32'h00000000);
        apply(32'h80000000); check_out("R2 nar word", 32'h80000000);
    endtask

    task automatic t_unit;
        apply(32'h40000000); check_out("R5 one", 32'h40000000);
        check_lit("R5 one literal", 32'h40000000, 8'd128);
        apply(32'hC0000000); check_out("R3 minus one", 32'hC0000000);
        apply(32'h3C000000); check_out("R6 short negative regime", 32'h3C000000);
    endtask

    task automatic t_extremes;
        apply(32'h7FFFFFFF); check_out("R5 largest", 32'h7FFFFFFF);
        check_lit("R5 largest literal", 32'h7FFFFFFF, 8'd248);
        apply(32'h00000001); check_out("R6 smallest", 32'h00000001);
        check_lit("R6 smallest literal", 32'h00000001, 8'd8);
        apply(32'h80000001); check_out("R3 negative largest", 32'h80000001);
    endtask

    task automatic t_truncation;
        apply(32'h00000003); check_out("R4 cut exponent", 32'h00000003);
        check_lit("R4 cut exponent literal", 32'h00000003, 8'd14);
        apply(32'h7FFFFFFE); check_out("R4 long positive regime", 32'h7FFFFFFE);
        apply(32'h00000006); check_out("R7 no fraction bits", 32'h00000006);
    endtask

    task automatic t_mixed;
        logic [31:0] w;
        w = 32'h4A3C5E17; apply(w); check_out("R7 dense fraction", w);
        w = 32'h1234ABCD; apply(w); check_out("R6 mixed", w);
        w = 32'h6DB6DB6D; apply(w); check_out("R5 mixed", w);
        w = -32'h4A3C5E17; apply(w); check_out("R3 negated dense", w);
        w = -32'h1234ABCD; apply(w); check_out("R3 negated mixed", w);
        w = 32'h40000001; apply(w); check_out("R7 last fraction bit", w);
    endtask

    task automatic t_stream;
        logic [31:0] vec [12];
        logic        vv  [12];
        for (int i = 0; i < 12; i++) begin
            vec[i] = 32'h9E3779B9 * (i + 1) + 32'h01234567;
            vv[i]  = (i % 4) != 3;
        end
        vec[5] = 32'h0;
        vec[6] = 32'h80000000;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                if (vv[i-2]) check_out("R8 stream", vec[i-2]);
                else begin
                    n_checks++;
                    if (out_valid !== 1'b0) begin
                        n_fail++;
                        $display("FAIL R8 gap actual out_valid=%b expected 0", out_valid);
                    end
                end
            end
            if (i < 12) begin in_valid = vv[i]; in_word = vec[i]; end
            else begin in_valid = 1'b0; in_word = '0; end
        end
    endtask

    initial begin
        #(200000 * 8);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset;
        t_specials;
        t_unit;
        t_extremes;
        t_truncation;
        t_mixed;
        t_stream;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule